// File: doc/BRIEF.md
# E3 Transmit Alarm and Maintenance Bit Inserter

This block is the last stage of an E3 transmit path. It walks a bit-serial frame of overhead bytes followed by payload bytes. For each bit it picks what goes to the line: a locally generated alignment pattern, overhead or payload bits from upstream, or the far-end status bits placed in the maintenance byte. On software request it replaces the whole stream with an alarm pattern. A loss-of-signal pattern (constant zero) always wins over an alarm-indication pattern (constant one, unframed).

Software reaches two 8-bit registers through a plain write/read port. A control register at address 0x30 has four fields. Bit 0 selects the far-end status source. Bit 1 requests the zero pattern. Bit 2 requests the ones pattern. Bit 4 routes a data-link input into the network-reserved overhead byte. A status-value register at address 0x31 holds the two far-end bits that software supplies. The pattern requests take effect only at frame boundaries. The frame position counter never stops.

Top module: `e3_maint_inserter`

## Requirements
- R1: After reset both registers read 0. At 0x30, bits 7, 6, 5 and 3 always read 0 and bits 4, 2, 1, 0 read back what was written. At 0x31 only bits 1:0 are kept. Any other address reads 0.
- R2: While the active pattern is the ones pattern and the zero pattern is not active, every transmitted bit is 1, including the alignment byte positions.
- R3: While the zero pattern (0x30 bit 1) is active, every transmitted bit is 0, including the alignment bytes, whatever the value of 0x30 bit 2.
- R4: With no pattern active, overhead bytes 0 and 1 carry 0xF6 and 0x28, sent MSB first. tx_sof is 1 on the first bit of byte 0.
- R5: With no pattern active, overhead bytes 2, 3 and 6 copy oh_bit, and bytes 7 and above copy pl_bit, in the same enabled cycle.
- R6: In overhead byte 4, the first transmitted bit carries the far-end block error and the second carries the far-end receive failure. With 0x30 bit 0 = 0 they come from rx_febe and rx_ferf. With 0x30 bit 0 = 1 they come from 0x31 bit 0 (block error) and bit 1 (failure). The remaining six bits copy oh_bit.
- R7: In overhead byte 5, the bit sent is dl_bit when 0x30 bit 4 is 1 and oh_bit when it is 0.
- R8: A change to 0x30 bits 1 or 2 alters the output only from the first bit of the next frame.
- R9: tx_sof recurs every FRAME_BYTES*8 enabled bits, also while a pattern is active.
- R10: When bit_en is 0, tx_bit and tx_sof hold their values and the frame position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Line bit strobe: one bit is produced per enabled cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for reads and writes |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr (combinational) |
| oh_bit | input | 1 | Overhead bit from upstream for the current position |
| pl_bit | input | 1 | Payload bit from upstream for the current position |
| dl_bit | input | 1 | Data-link bit for the network-reserved byte |
| rx_febe | input | 1 | Far-end block error status from the receive side |
| rx_ferf | input | 1 | Far-end receive failure status from the receive side |
| tx_bit | output | 1 | Registered line bit |
| tx_sof | output | 1 | Registered marker of the first bit of a frame |

## Verification
The bench builds the block with a 12-byte frame: 7 overhead bytes and 5 payload bytes. This makes each frame 96 bits long, so dozens of frame boundaries occur in a short run. Every pattern request lands at a random point inside a frame, so the deferral to the boundary is exercised many times. The default 537-byte geometry uses the same counter and selection logic. Only the wrap point changes.

// File: rtl/e3_maint_pkg.sv
package e3_maint_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'd0,
      MODE_AIS    = 2'd1,
      MODE_LOS    = 2'd2
   } e3_mode_t;

   typedef struct packed {
      logic dl_nr;
      logic ais_req;
      logic los_req;
      logic ma_sw;
      logic sw_febe;
      logic sw_ferf;
   } e3_ctl_t;

   function automatic e3_mode_t pick_mode(input logic los, input logic ais);
      if (los)      return MODE_LOS;
      else if (ais) return MODE_AIS;
      else          return MODE_NORMAL;
   endfunction

endpackage

// File: rtl/e3_cfg_regs.sv
module e3_cfg_regs
   import e3_maint_pkg::*;
#(
   parameter int          AW        = 8,
   parameter logic [7:0]  CTL_ADDR  = 8'h30,
   parameter logic [7:0]  STAT_ADDR = 8'h31,
   parameter int          DL_POS    = 4,
   parameter int          AIS_POS   = 2,
   parameter int          LOS_POS   = 1,
   parameter int          MASW_POS  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata,
   output e3_ctl_t       ctl
);
   localparam logic [AW-1:0] CTL_A  = AW'(CTL_ADDR);
   localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);

   logic [7:0] ctl_view;
   logic [7:0] stat_view;
   logic       unused_wbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (we) begin
         if (addr == CTL_A) begin
            ctl.dl_nr   <= wdata[DL_POS];
            ctl.ais_req <= wdata[AIS_POS];
            ctl.los_req <= wdata[LOS_POS];
            ctl.ma_sw   <= wdata[MASW_POS];
         end
         if (addr == STAT_A) begin
            ctl.sw_febe <= wdata[0];
            ctl.sw_ferf <= wdata[1];
         end
      end
   end

   for (genvar b = 0; b < 8; b++) begin : g_view
      if (b == DL_POS) begin : g_dl
         assign ctl_view[b] = ctl.dl_nr;
      end else if (b == AIS_POS) begin : g_ais
         assign ctl_view[b] = ctl.ais_req;
      end else if (b == LOS_POS) begin : g_los
         assign ctl_view[b] = ctl.los_req;
      end else if (b == MASW_POS) begin : g_ma
         assign ctl_view[b] = ctl.ma_sw;
      end else begin : g_zero
         assign ctl_view[b] = 1'b0;
      end
   end

   assign stat_view = {6'd0, ctl.sw_ferf, ctl.sw_febe};

   always_comb begin
      if (addr == CTL_A)       rdata = ctl_view;
      else if (addr == STAT_A) rdata = stat_view;
      else                     rdata = 8'd0;
   end

   assign unused_wbits = ^wdata;
endmodule

// File: rtl/e3_frame_pos.sv
module e3_frame_pos #(
   parameter int FRAME_BYTES = 537,
   parameter int BYTE_W      = $clog2(FRAME_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   output logic [BYTE_W-1:0] byte_idx,
   output logic [2:0]        bit_idx,
   output logic              at_sof,
   output logic              at_eof
);
   localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(FRAME_BYTES - 1);

   assign at_sof = (byte_idx == '0) && (bit_idx == 3'd0);
   assign at_eof = (byte_idx == LAST_BYTE) && (bit_idx == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_idx <= '0;
         bit_idx  <= 3'd0;
      end else if (adv) begin
         bit_idx <= bit_idx + 3'd1;
         if (bit_idx == 3'd7) begin
            byte_idx <= at_eof ? '0 : byte_idx + BYTE_W'(1);
         end
      end
   end
endmodule

// File: rtl/e3_bit_sel.sv
module e3_bit_sel
   import e3_maint_pkg::*;
#(
   parameter int         BYTE_W    = 10,
   parameter int         OH_BYTES  = 7,
   parameter int         MA_IDX    = 4,
   parameter int         NR_IDX    = 5,
   parameter logic [7:0] FA1_PAT   = 8'hF6,
   parameter logic [7:0] FA2_PAT   = 8'h28,
   parameter bit         MSB_FIRST = 1'b1
) (
   input  e3_mode_t          mode,
   input  logic [BYTE_W-1:0] byte_idx,
   input  logic [2:0]        bit_idx,
   input  logic              oh_bit,
   input  logic              pl_bit,
   input  logic              dl_bit,
   input  logic              dl_nr,
   input  logic              febe,
   input  logic              ferf,
   output logic              line_bit
);
   localparam logic [BYTE_W-1:0] B_FA1 = BYTE_W'(0);
   localparam logic [BYTE_W-1:0] B_FA2 = BYTE_W'(1);
   localparam logic [BYTE_W-1:0] B_MA  = BYTE_W'(MA_IDX);
   localparam logic [BYTE_W-1:0] B_NR  = BYTE_W'(NR_IDX);
   localparam logic [BYTE_W-1:0] B_PL  = BYTE_W'(OH_BYTES);

   logic [2:0] pat_idx;
   logic       framed_bit;

   if (MSB_FIRST) begin : g_msb
      assign pat_idx = 3'd7 - bit_idx;
   end else begin : g_lsb
      assign pat_idx = bit_idx;
   end

   always_comb begin
      if (byte_idx >= B_PL)        framed_bit = pl_bit;
      else if (byte_idx == B_FA1)  framed_bit = FA1_PAT[pat_idx];
      else if (byte_idx == B_FA2)  framed_bit = FA2_PAT[pat_idx];
      else if (byte_idx == B_MA) begin
         if (bit_idx == 3'd0)      framed_bit = febe;
         else if (bit_idx == 3'd1) framed_bit = ferf;
         else                      framed_bit = oh_bit;
      end
      else if (byte_idx == B_NR)   framed_bit = dl_nr ? dl_bit : oh_bit;
      else                         framed_bit = oh_bit;
   end

   always_comb begin
      unique case (mode)
         MODE_LOS: line_bit = 1'b0;
         MODE_AIS: line_bit = 1'b1;
         default:  line_bit = framed_bit;
      endcase
   end
endmodule

// File: rtl/e3_maint_inserter.sv
module e3_maint_inserter
   import e3_maint_pkg::*;
#(
   parameter int         FRAME_BYTES = 537,
   parameter int         OH_BYTES    = 7,
   parameter int         MA_IDX      = 4,
   parameter int         NR_IDX      = 5,
   parameter logic [7:0] FA1_PAT     = 8'hF6,
   parameter logic [7:0] FA2_PAT     = 8'h28,
   parameter logic [7:0] CTL_ADDR    = 8'h30,
   parameter logic [7:0] STAT_ADDR   = 8'h31,
   parameter bit         MSB_FIRST   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       cfg_we,
   input  logic [7:0] cfg_addr,
   input  logic [7:0] cfg_wdata,
   output logic [7:0] cfg_rdata,
   input  logic       oh_bit,
   input  logic       pl_bit,
   input  logic       dl_bit,
   input  logic       rx_febe,
   input  logic       rx_ferf,
   output logic       tx_bit,
   output logic       tx_sof
);
   localparam int BYTE_W = $clog2(FRAME_BYTES);

   if (FRAME_BYTES <= OH_BYTES) begin : g_bad_frame
      $error("frame must be longer than its overhead");
   end
   if (MA_IDX < 2 || MA_IDX >= OH_BYTES || NR_IDX < 2 || NR_IDX >= OH_BYTES
       || MA_IDX == NR_IDX) begin : g_bad_slot
      $error("maintenance and reserved bytes must be distinct overhead slots");
   end

   e3_ctl_t           ctl;
   e3_mode_t          act_mode;
   logic [BYTE_W-1:0] byte_idx;
   logic [2:0]        bit_idx;
   logic              at_sof, at_eof;
   logic              febe, ferf, line_bit;

   e3_cfg_regs #(
      .AW(8), .CTL_ADDR(CTL_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .ctl(ctl)
   );

   e3_frame_pos #(.FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .adv(bit_en), .byte_idx(byte_idx),
      .bit_idx(bit_idx), .at_sof(at_sof), .at_eof(at_eof)
   );

   assign febe = ctl.ma_sw ? ctl.sw_febe : rx_febe;
   assign ferf = ctl.ma_sw ? ctl.sw_ferf : rx_ferf;

   e3_bit_sel #(
      .BYTE_W(BYTE_W), .OH_BYTES(OH_BYTES), .MA_IDX(MA_IDX), .NR_IDX(NR_IDX),
      .FA1_PAT(FA1_PAT), .FA2_PAT(FA2_PAT), .MSB_FIRST(MSB_FIRST)
   ) u_sel (
      .mode(act_mode), .byte_idx(byte_idx), .bit_idx(bit_idx),
      .oh_bit(oh_bit), .pl_bit(pl_bit), .dl_bit(dl_bit), .dl_nr(ctl.dl_nr),
      .febe(febe), .ferf(ferf), .line_bit(line_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_mode <= MODE_NORMAL;
         tx_bit   <= 1'b0;
         tx_sof   <= 1'b0;
      end else if (bit_en) begin
         tx_bit <= line_bit;
         tx_sof <= at_sof;
         if (at_eof) act_mode <= pick_mode(ctl.los_req, ctl.ais_req);
      end
   end
endmodule

// File: rtl/e3_maint_chk.sv
module e3_maint_chk
   import e3_maint_pkg::*;
#(
   parameter int         FRAME_BYTES = 537,
   parameter int         BYTE_W      = 10,
   parameter logic [7:0] CTL_ADDR    = 8'h30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_en,
   input logic              tx_bit,
   input logic              tx_sof,
   input e3_mode_t          act_mode,
   input logic [BYTE_W-1:0] byte_idx,
   input logic [2:0]        bit_idx,
   input logic [7:0]        cfg_addr,
   input logic [7:0]        cfg_rdata
);
   localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(FRAME_BYTES - 1);

   assert_los_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && act_mode == MODE_LOS) |=> !tx_bit);

   assert_ais_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && act_mode == MODE_AIS) |=> tx_bit);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(tx_bit) && $stable(tx_sof)));

   assert_mode_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_en && byte_idx == LAST_BYTE && bit_idx == 3'd7) |=> $stable(act_mode));

   assert_sof_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && byte_idx == '0 && bit_idx == 3'd0) |=> tx_sof);

   always_comb begin
      if (rst_n && cfg_addr == CTL_ADDR) begin
         assert_unused_zero_R1: assert (cfg_rdata[7:5] == 3'd0 && cfg_rdata[3] == 1'b0);
      end
   end
endmodule

bind e3_maint_inserter e3_maint_chk #(
   .FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W), .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit), .tx_sof(tx_sof),
   .act_mode(act_mode), .byte_idx(byte_idx), .bit_idx(bit_idx),
   .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_e3_maint_inserter.sv
module sim_e3_maint_inserter;
   localparam int FB    = 12;
   localparam int FBITS = FB * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, cfg_we = 1'b0;
   logic [7:0] cfg_addr = 8'd0, cfg_wdata = 8'd0, cfg_rdata;
   logic oh_bit = 1'b0, pl_bit = 1'b0, dl_bit = 1'b0, rx_febe = 1'b0, rx_ferf = 1'b0;
   logic tx_bit, tx_sof;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   e3_maint_inserter #(.FRAME_BYTES(FB)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .oh_bit(oh_bit), .pl_bit(pl_bit), .dl_bit(dl_bit),
      .rx_febe(rx_febe), .rx_ferf(rx_ferf), .tx_bit(tx_bit), .tx_sof(tx_sof)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // random line-side stimulus
   always @(negedge clk) begin
      bit_en  <= ($urandom % 5) != 0;
      oh_bit  <= $urandom;
      pl_bit  <= $urandom;
      dl_bit  <= $urandom;
      rx_febe <= $urandom;
      rx_ferf <= $urandom;
   end

   // behavioural reference model
   bit   r_dl, r_ais, r_los, r_ma, r_febe, r_ferf;
   bit   m_ais, m_los;
   int   m_pos;
   bit   e_bit, e_sof;
   string e_tag = "R1";
   bit [7:0] fa1 = 8'hF6, fa2 = 8'h28;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {r_dl, r_ais, r_los, r_ma, r_febe, r_ferf} <= '0;
         {m_ais, m_los} <= '0;
         m_pos <= 0; e_bit <= 0; e_sof <= 0; e_tag <= "R1";
      end else begin
         if (cfg_we && cfg_addr == 8'h30) begin
            r_dl <= cfg_wdata[4]; r_ais <= cfg_wdata[2];
            r_los <= cfg_wdata[1]; r_ma <= cfg_wdata[0];
         end
         if (cfg_we && cfg_addr == 8'h31) begin
            r_febe <= cfg_wdata[0]; r_ferf <= cfg_wdata[1];
         end
         if (bit_en) begin
            int byt, bi;
            byt = m_pos / 8; bi = m_pos % 8;
            e_sof <= (m_pos == 0);
            if (m_los) begin e_bit <= 1'b0; e_tag <= "R3"; end
            else if (m_ais) begin e_bit <= 1'b1; e_tag <= "R2"; end
            else if (byt == 0) begin e_bit <= fa1[7-bi]; e_tag <= "R4"; end
            else if (byt == 1) begin e_bit <= fa2[7-bi]; e_tag <= "R4"; end
            else if (byt == 4) begin
               e_tag <= "R6";
               if (bi == 0)      e_bit <= r_ma ? r_febe : rx_febe;
               else if (bi == 1) e_bit <= r_ma ? r_ferf : rx_ferf;
               else              e_bit <= oh_bit;
            end
            else if (byt == 5) begin e_bit <= r_dl ? dl_bit : oh_bit; e_tag <= "R7"; end
            else if (byt < 7) begin e_bit <= oh_bit; e_tag <= "R5"; end
            else begin e_bit <= pl_bit; e_tag <= "R5"; end
            if ((m_los != r_los) || (m_ais != r_ais)) e_tag <= "R8";
            if (m_pos == FBITS - 1) begin
               m_pos <= 0; m_los <= r_los; m_ais <= r_ais;
            end else begin
               m_pos <= m_pos + 1;
            end
         end else begin
            e_tag <= "R10";
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(e_tag, {7'd0, tx_bit}, {7'd0, e_bit});
         chk("R9", {7'd0, tx_sof}, {7'd0, e_sof});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
      @(negedge clk); cfg_we = 1'b0; cfg_addr = 8'd0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk); cfg_addr = a; #1;
      chk(tag, cfg_rdata, exp);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk("R1", {6'd0, tx_bit, tx_sof}, 8'd0);
      rst_n = 1'b1;
      rd(8'h30, 8'h00, "R1");
      rd(8'h31, 8'h00, "R1");
      wr(8'h30, 8'hFF);
      rd(8'h30, 8'h17, "R1");
      wr(8'h31, 8'hFF);
      rd(8'h31, 8'h03, "R1");
      rd(8'h32, 8'h00, "R1");
      wr(8'h30, 8'h00);
      wr(8'h31, 8'h00);
      repeat (300) @(negedge clk);             // normal, receive-side status R6
      wr(8'h31, 8'h02);
      wr(8'h30, 8'h01);                        // software status R6
      repeat (250) @(negedge clk);
      wr(8'h31, 8'h01);
      repeat (250) @(negedge clk);
      wr(8'h30, 8'h10);                        // data link in reserved byte R7
      repeat (250) @(negedge clk);
      wr(8'h30, 8'h04);                        // ones pattern R2 R8
      repeat (300) @(negedge clk);
      wr(8'h30, 8'h06);                        // both set, zeros win R3
      repeat (300) @(negedge clk);
      wr(8'h30, 8'h02);
      repeat (250) @(negedge clk);
      wr(8'h30, 8'h00);                        // back to traffic R8
      repeat (300) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog R9 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule